// File: doc/BRIEF.md
# Edge-Triggered Interrupt and Event Line Controller

This block watches a set of asynchronous input lines and converts selected transitions on them into interrupt requests or one-cycle event pulses. Each line is first brought into the clock domain through a synchronizer chain. Its settled value is then compared with the value one cycle earlier. For each line, software picks the trigger edges (rising, falling, both or none). Software also picks where a trigger goes: a sticky pending bit that drives an interrupt level, a single-cycle event strobe, or both.

A small word-wide register port holds the configuration and the pending bits. Software uses the same port to fire a line by hand and to clear pending bits by writing ones. There is one interrupt level and one event strobe per line. Prioritization and vectoring are the job of whatever consumes these outputs.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset, every configuration register and every pending bit is zero, so `irq_o`, `evt_o` and all register reads return zero.
- R2: The register map at `bus_addr` is: 0 = rising-edge enable, 1 = falling-edge enable, 2 = interrupt enable, 3 = event enable, 4 = software trigger, 5 = pending. Bit i of each register belongs to line i. Addresses 0 to 3 read back the last value written. Address 4 always reads zero. Address 5 reads the pending bits. Addresses 6 and 7 read zero and ignore writes.
- R3: With its rising enable set, a 0-to-1 change on `ext_in[i]` is a trigger. The change is applied just after a clock edge. The resulting pending bit and event strobe become visible after the third following rising clock edge.
- R4: With its falling enable set, a 1-to-0 change on `ext_in[i]` is a trigger, with the same three-edge latency as R3.
- R5: A line with both edge enables set triggers on both transitions. A line with both enables clear never triggers from its input.
- R6: A trigger sets pending bit i only when interrupt enable bit i is 1. Otherwise the pending bit is left unchanged.
- R7: A trigger raises `evt_o[i]` for exactly one cycle, only when event enable bit i is 1. The strobe is not latched.
- R8: A pending bit stays set until a write to address 5 has a 1 in its position. Writing 0 leaves it unchanged.
- R9: When a trigger and a clear reach the same pending bit in the same cycle, the bit ends up set.
- R10: Writing 1 to bit i of address 4 triggers line i at that clock edge, whatever its edge enables say. Its pending and event results follow R6 and R7 and become visible right after the write edge.
- R11: `irq_o[i]` is pending bit i AND interrupt enable bit i, with no added delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| ext_in | input | NUM_LINES | Asynchronous input lines |
| bus_wr | input | 1 | Register write strobe for one cycle |
| bus_addr | input | 3 | Register select |
| bus_wdata | input | NUM_LINES | Write data |
| bus_rdata | output | NUM_LINES | Combinational read data for `bus_addr` |
| irq_o | output | NUM_LINES | Interrupt level per line |
| evt_o | output | NUM_LINES | One-cycle event strobe per line |

## Verification
Assertions check several properties on every cycle. A pending bit never drops unless a clear targeted it. A clear that meets no trigger empties the bit. A simultaneous trigger wins over a clear. Pending never rises without a trigger or on a line whose interrupt enable was off. Event strobes never appear on lines whose event enable was off.

Only the bench scenarios can show the rest. These are the exact three-edge latency from input to output, and the edge-polarity choice for each line across all sixteen configuration combinations. The bench also covers how software triggers behave next to the edge enables, register readback, and the one-cycle width of the strobe.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;
   localparam int REG_AW = 3;

   typedef enum logic [REG_AW-1:0] {
      SEL_RISE  = 3'd0,
      SEL_FALL  = 3'd1,
      SEL_INTEN = 3'd2,
      SEL_EVTEN = 3'd3,
      SEL_SWTRG = 3'd4,
      SEL_PEND  = 3'd5
   } reg_sel_e;
endpackage

// File: rtl/eic_sync_edge.sv
module eic_sync_edge #(
   parameter int NUM_LINES   = 23,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] async_in,
   input  logic [NUM_LINES-1:0] rise_en,
   input  logic [NUM_LINES-1:0] fall_en,
   output logic [NUM_LINES-1:0] trig_o
);
   localparam int MSB = SYNC_STAGES - 1;

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("SYNC_STAGES must be at least 2");
   end

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      logic [MSB:0] chain;
      logic         prev;
      logic         now_v;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            chain <= '0;
            prev  <= 1'b0;
         end else begin
            chain <= {chain[MSB-1:0], async_in[i]};
            prev  <= chain[MSB];
         end
      end

      assign now_v     = chain[MSB];
      assign trig_o[i] = (now_v & ~prev & rise_en[i]) |
                         (~now_v & prev & fall_en[i]);
   end
endmodule

// File: rtl/eic_regs.sv
module eic_regs
   import edge_irq_pkg::*;
#(
   parameter int NUM_LINES = 23
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_wr,
   input  logic [REG_AW-1:0]    bus_addr,
   input  logic [NUM_LINES-1:0] bus_wdata,
   input  logic [NUM_LINES-1:0] pend_q,
   output logic [NUM_LINES-1:0] bus_rdata,
   output logic [NUM_LINES-1:0] rise_en,
   output logic [NUM_LINES-1:0] fall_en,
   output logic [NUM_LINES-1:0] int_en,
   output logic [NUM_LINES-1:0] evt_en,
   output logic [NUM_LINES-1:0] sw_trig,
   output logic [NUM_LINES-1:0] clr_vec
);
   reg_sel_e sel;
   assign sel = reg_sel_e'(bus_addr);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rise_en <= '0;
         fall_en <= '0;
         int_en  <= '0;
         evt_en  <= '0;
      end else if (bus_wr) begin
         case (sel)
            SEL_RISE:  rise_en <= bus_wdata;
            SEL_FALL:  fall_en <= bus_wdata;
            SEL_INTEN: int_en  <= bus_wdata;
            SEL_EVTEN: evt_en  <= bus_wdata;
            default: ;
         endcase
      end
   end

   assign sw_trig = (bus_wr && sel == SEL_SWTRG) ? bus_wdata : '0;
   assign clr_vec = (bus_wr && sel == SEL_PEND)  ? bus_wdata : '0;

   always_comb begin
      case (sel)
         SEL_RISE:  bus_rdata = rise_en;
         SEL_FALL:  bus_rdata = fall_en;
         SEL_INTEN: bus_rdata = int_en;
         SEL_EVTEN: bus_rdata = evt_en;
         SEL_PEND:  bus_rdata = pend_q;
         default:   bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/eic_pending.sv
module eic_pending #(
   parameter int NUM_LINES = 23
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] set_vec,
   input  logic [NUM_LINES-1:0] clr_vec,
   output logic [NUM_LINES-1:0] pend_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~clr_vec) | set_vec;
   end

   // A pending bit only drops where a clear was aimed at it (R8)
   assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(pend_q) & ~$past(clr_vec) & ~pend_q) == '0);

   // Clear with no competing set empties the bit (R8)
   assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      |(clr_vec & ~set_vec) |=> ((pend_q & $past(clr_vec & ~set_vec)) == '0));

   // Set wins over a simultaneous clear (R9)
   assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      |set_vec |=> ((pend_q & $past(set_vec)) == $past(set_vec)));

   // No pending bit appears without a set
   assert_no_spurious_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q & ~$past(pend_q) & ~$past(set_vec)) == '0);
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
   import edge_irq_pkg::*;
#(
   parameter int NUM_LINES   = 23,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] ext_in,
   input  logic                 bus_wr,
   input  logic [REG_AW-1:0]    bus_addr,
   input  logic [NUM_LINES-1:0] bus_wdata,
   output logic [NUM_LINES-1:0] bus_rdata,
   output logic [NUM_LINES-1:0] irq_o,
   output logic [NUM_LINES-1:0] evt_o
);
   if (NUM_LINES < 1 || NUM_LINES > 32) begin : g_bad_lines
      $error("NUM_LINES must be within 1..32");
   end

   logic [NUM_LINES-1:0] rise_en, fall_en, int_en, evt_en;
   logic [NUM_LINES-1:0] sw_trig, clr_vec, hw_trig, any_trig;
   logic [NUM_LINES-1:0] set_vec, pend_q, evt_q;

   eic_regs #(.NUM_LINES(NUM_LINES)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .pend_q(pend_q), .bus_rdata(bus_rdata),
      .rise_en(rise_en), .fall_en(fall_en), .int_en(int_en),
      .evt_en(evt_en), .sw_trig(sw_trig), .clr_vec(clr_vec)
   );

   eic_sync_edge #(.NUM_LINES(NUM_LINES), .SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .async_in(ext_in),
      .rise_en(rise_en), .fall_en(fall_en), .trig_o(hw_trig)
   );

   assign any_trig = hw_trig | sw_trig;
   assign set_vec  = any_trig & int_en;

   eic_pending #(.NUM_LINES(NUM_LINES)) u_pend (
      .clk(clk), .rst_n(rst_n), .set_vec(set_vec),
      .clr_vec(clr_vec), .pend_q(pend_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) evt_q <= '0;
      else        evt_q <= any_trig & evt_en;
   end

   assign evt_o = evt_q;
   assign irq_o = pend_q & int_en;

   // Pending never rises on a line whose interrupt enable was off (R6)
   assert_mask_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q & ~$past(pend_q) & ~$past(int_en)) == '0);

   // Strobes only on lines whose event enable was on (R7)
   assert_evt_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_o & ~$past(evt_en)) == '0);

   // An interrupt level needs a pending bit behind it (R11)
   assert_irq_src_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o & ~pend_q) == '0);
endmodule

// File: tb/sim_edge_irq_ctrl.sv
module sim_edge_irq_ctrl;
   localparam int N = 23;
   localparam logic [N-1:0] ALL = '1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [N-1:0] ext_in = '0;
   logic bus_wr = 1'b0;
   logic [2:0] bus_addr = '0;
   logic [N-1:0] bus_wdata = '0;
   logic [N-1:0] bus_rdata, irq_o, evt_o;

   int checks = 0;
   int fails = 0;

   always #2 clk = ~clk;

   edge_irq_ctrl #(.NUM_LINES(N)) u0 (
      .clk(clk), .rst_n(rst_n), .ext_in(ext_in), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_o(irq_o), .evt_o(evt_o)
   );

   task automatic check(input logic [N-1:0] act, input logic [N-1:0] exp,
                        input string tag);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [2:0] a, input logic [N-1:0] exp,
                     input string tag);
      bus_addr = a;
      #1;
      check(bus_rdata, exp, tag);
   endtask

   // Apply input at a negedge, wait three edges, sample at the negedge
   task automatic drive_in(input logic [N-1:0] v);
      ext_in = v;
      repeat (3) @(posedge clk);
      @(negedge clk);
   endtask

   logic [N-1:0] rv, fv, iv, ev;

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      rv = '0; fv = '0; iv = '0; ev = '0;
      for (int i = 0; i < 16; i++) begin
         rv[i] = i[0]; fv[i] = i[1]; iv[i] = i[2]; ev[i] = i[3];
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check(irq_o, '0, "R1 irq");
      check(evt_o, '0, "R1 evt");
      for (int a = 0; a < 8; a++) rd(3'(a), '0, "R1 read");

      // R2 register map
      wr(3'd0, rv); wr(3'd1, fv); wr(3'd2, iv); wr(3'd3, ev);
      rd(3'd0, rv, "R2 rise");
      rd(3'd1, fv, "R2 fall");
      rd(3'd2, iv, "R2 inten");
      rd(3'd3, ev, "R2 evten");
      wr(3'd6, ALL); wr(3'd7, ALL);
      rd(3'd6, '0, "R2 addr6");
      rd(3'd7, '0, "R2 addr7");
      rd(3'd0, rv, "R2 rise kept");
      rd(3'd4, '0, "R2 swtrig reads 0");
      check(evt_o, '0, "R2 no event from config");

      // R3 R5 R6 rising sweep across all 16 combinations
      ext_in = '1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      check(irq_o, '0, "R3 not before third edge");
      @(posedge clk); @(negedge clk);
      rd(3'd5, rv & iv, "R3 R5 R6 pending rising");
      check(evt_o, rv & ev, "R3 R7 event rising");
      check(irq_o, rv & iv, "R11 irq rising");
      @(negedge clk);
      check(evt_o, '0, "R7 strobe one cycle");
      rd(3'd5, rv & iv, "R8 pending held");

      // R8 write zero no effect, write ones clears
      wr(3'd5, '0);
      rd(3'd5, rv & iv, "R8 zero write");
      wr(3'd5, ALL);
      rd(3'd5, '0, "R8 clear");

      // R4 R5 falling sweep
      drive_in('0);
      rd(3'd5, fv & iv, "R4 R5 pending falling");
      check(evt_o, fv & ev, "R4 R7 event falling");
      @(negedge clk);
      check(evt_o, '0, "R7 falling strobe one cycle");

      // R11 mask removal drops irq, keeps pending
      wr(3'd2, '0);
      check(irq_o, '0, "R11 irq masked");
      rd(3'd5, fv & iv, "R11 pending kept");
      wr(3'd2, iv);
      check(irq_o, fv & iv, "R11 irq restored");
      wr(3'd5, ALL);

      // R10 software trigger ignores edge enables
      wr(3'd0, '0); wr(3'd1, '0);
      bus_wr = 1'b1; bus_addr = 3'd4; bus_wdata = ALL;
      @(posedge clk); @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
      rd(3'd5, iv, "R10 sw pending");
      check(evt_o, ev, "R10 sw event");
      @(negedge clk);
      check(evt_o, '0, "R10 sw strobe one cycle");
      wr(3'd5, ALL);

      // R5 no edge enables: input toggles do nothing
      drive_in(ALL);
      rd(3'd5, '0, "R5 none rise");
      check(evt_o, '0, "R5 none rise evt");
      drive_in('0);
      rd(3'd5, '0, "R5 none fall");

      // R9 trigger and clear in the same cycle
      wr(3'd0, ALL); wr(3'd2, ALL);
      ext_in[20] = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 3'd5; bus_wdata = ALL;
      @(posedge clk); @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
      rd(3'd5, N'(1) << 20, "R9 set wins");
      check(irq_o, N'(1) << 20, "R9 irq");
      wr(3'd5, ALL);
      rd(3'd5, '0, "R9 later clear");

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule